// File: doc/BRIEF.md
# Register Rename Unit

This unit turns the architectural register names of one instruction per cycle into physical register tags for a small out-of-order core. A register alias table gives the current physical register of every architectural register. A free list records the physical registers that hold no live value. When an instruction writes a register, the unit gives it a fresh physical register. It also returns the physical register that held that name before, so that the register can be released later when the instruction commits.

The unit keeps one saved copy of the whole alias table. The copy is taken when a branch is renamed and is written back into the live table when that branch turns out to be mispredicted. Physical registers come back to the free list on two ports: one for commit, which returns the replaced mappings, and one for squash, which returns the registers of discarded instructions. If a destination is needed and no register is free, the unit holds the instruction back with a stall.

The rename outputs are combinational and are read from the current state. Every change to the alias table, the free list or the saved copy takes effect at the next rising clock edge.

Top module: `rename_unit`

## Requirements
- R1: After reset, architectural register rN maps to physical register pN. Physical registers ARCH_REGS up to PHYS_REGS-1 are free, and all others are allocated.
- R2: A renamed instruction whose destination is not r0 receives the lowest-numbered free physical register on `rn_pdst`. From the next cycle on, sources that name that destination read the new tag.
- R3: `rn_pold` gives the physical register that the destination was mapped to just before this instruction's allocation.
- R4: A source that names the instruction's own destination is translated with the mapping in force before this instruction's update.
- R5: An instruction with `rn_has_dst` low, or with destination r0, allocates nothing and leaves the table unchanged. It drives `rn_pdst` and `rn_pold` as 0 and never stalls for lack of free registers.
- R6: `rn_stall` is high when `rn_valid` is high and either the free list is empty while a destination is needed, or `mispredict` is high. A stalled instruction changes neither the table nor the free list.
- R7: When a branch (`rn_branch` high) is renamed without a stall, the alias table is saved, including that instruction's own destination update.
- R8: When `mispredict` is high, the live table is replaced by the saved copy at the next edge, and a rename offered in that cycle is stalled.
- R9: A tag presented on `cm_free_tag` with `cm_free_valid`, or on `sq_free_tag` with `sq_free_valid`, is free from the next cycle on. Both ports may be used in the same cycle.
- R10: A source naming r0 always translates to p0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rn_valid | input | 1 | An instruction is offered for rename |
| rn_has_dst | input | 1 | The instruction writes a destination register |
| rn_dst | input | AW | Architectural destination |
| rn_src1 | input | AW | Architectural source 1 |
| rn_src2 | input | AW | Architectural source 2 |
| rn_branch | input | 1 | The instruction is a branch; save the table |
| mispredict | input | 1 | Restore the table from the saved copy |
| cm_free_valid | input | 1 | Commit returns a tag |
| cm_free_tag | input | PW | Tag returned by commit |
| sq_free_valid | input | 1 | Squash returns a tag |
| sq_free_tag | input | PW | Tag returned by squash |
| rn_stall | output | 1 | The offered rename did not take place |
| rn_psrc1 | output | PW | Physical tag of source 1 |
| rn_psrc2 | output | PW | Physical tag of source 2 |
| rn_pdst | output | PW | Newly allocated destination tag |
| rn_pold | output | PW | Previous mapping of the destination |

## Verification
The bench first drains the free list completely. It checks that the next destination-writing instruction stalls and leaves the table untouched, while instructions with no destination or with r0 as destination still pass. A design that allocated from an empty list would hand out a tag that is already in use. A source equal to the destination is read in the same cycle as the update; a design that forwarded the new tag would make an instruction read its own result. A branch that also writes a register is checkpointed, and a later restore must bring back that branch's mapping. A design that saved the table before the branch's update would lose the branch's mapping after a mispredict. Commit and squash return tags in the same cycle, and a long mixed sequence then checks that allocation always picks the lowest free tag.

// File: rtl/rename_pkg.sv
package rename_pkg;

  // A destination is allocated only for a real write to a non-zero register.
  function automatic logic needs_dest(input logic has_dst, input logic dst_nonzero);
    return has_dst & dst_nonzero;
  endfunction

endpackage

// File: rtl/rename_freelist.sv
module rename_freelist #(
  parameter int ARCH_REGS = 32,
  parameter int PHYS_REGS = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          alloc_en_i,
  input  logic                          free_a_v_i,
  input  logic [$clog2(PHYS_REGS)-1:0]  free_a_tag_i,
  input  logic                          free_b_v_i,
  input  logic [$clog2(PHYS_REGS)-1:0]  free_b_tag_i,
  output logic                          empty_o,
  output logic [$clog2(PHYS_REGS)-1:0]  alloc_tag_o
);
  localparam int PW = $clog2(PHYS_REGS);
  localparam logic [PHYS_REGS-1:0] INIT_FREE = {PHYS_REGS{1'b1}} << ARCH_REGS;

  logic [PHYS_REGS-1:0] free_q, free_d;
  logic                 upd_en;

  // Lowest-numbered free register wins.
  always_comb begin
    alloc_tag_o = '0;
    for (int i = PHYS_REGS - 1; i >= 0; i--) begin
      if (free_q[i]) alloc_tag_o = PW'(i);
    end
  end

  assign empty_o = ~|free_q;
  assign upd_en  = alloc_en_i | free_a_v_i | free_b_v_i;

  always_comb begin
    free_d = free_q;
    if (alloc_en_i) free_d[alloc_tag_o]  = 1'b0;
    if (free_a_v_i) free_d[free_a_tag_i] = 1'b1;
    if (free_b_v_i) free_d[free_b_tag_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      free_q <= INIT_FREE;
    else if (upd_en) free_q <= free_d;
  end

  assert_alloc_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en_i && !empty_o && !free_a_v_i && !free_b_v_i |=> !free_q[$past(alloc_tag_o)]);

  assert_commit_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
    free_a_v_i |=> free_q[$past(free_a_tag_i)]);

  assert_squash_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
    free_b_v_i |=> free_q[$past(free_b_tag_i)]);

endmodule

// File: rtl/rename_map.sv
module rename_map #(
  parameter int ARCH_REGS = 32,
  parameter int PHYS_REGS = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [$clog2(ARCH_REGS)-1:0]  src1_i,
  input  logic [$clog2(ARCH_REGS)-1:0]  src2_i,
  input  logic [$clog2(ARCH_REGS)-1:0]  dst_i,
  input  logic                          wr_en_i,
  input  logic [$clog2(PHYS_REGS)-1:0]  wr_tag_i,
  input  logic                          ckpt_en_i,
  input  logic                          restore_i,
  output logic [$clog2(PHYS_REGS)-1:0]  psrc1_o,
  output logic [$clog2(PHYS_REGS)-1:0]  psrc2_o,
  output logic [$clog2(PHYS_REGS)-1:0]  pold_o
);
  localparam int PW = $clog2(PHYS_REGS);
  localparam int MW = ARCH_REGS * PW;

  function automatic logic [MW-1:0] identity_map();
    logic [MW-1:0] m;
    m = '0;
    for (int i = 0; i < ARCH_REGS; i++) m[i*PW +: PW] = PW'(i);
    return m;
  endfunction

  localparam logic [MW-1:0] INIT_MAP = identity_map();

  logic [MW-1:0] map_q, map_d, ckpt_q, ckpt_d;
  logic          map_en;

  // Reads use the map as it stands before this cycle's write.
  assign psrc1_o = map_q[src1_i*PW +: PW];
  assign psrc2_o = map_q[src2_i*PW +: PW];
  assign pold_o  = map_q[dst_i*PW +: PW];

  assign map_en = restore_i | wr_en_i;

  always_comb begin
    map_d = map_q;
    if (restore_i)    map_d = ckpt_q;
    else if (wr_en_i) map_d[dst_i*PW +: PW] = wr_tag_i;
  end

  // The saved copy includes the branch's own update.
  assign ckpt_d = map_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      map_q <= INIT_MAP;
    else if (map_en) map_q <= map_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ckpt_q <= INIT_MAP;
    else if (ckpt_en_i) ckpt_q <= ckpt_d;
  end

  assert_restore_map_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restore_i |=> map_q == $past(ckpt_q));

  assert_r0_src1_R10: assert property (@(posedge clk) disable iff (!rst_n)
    src1_i == '0 |-> psrc1_o == '0);

  assert_r0_src2_R10: assert property (@(posedge clk) disable iff (!rst_n)
    src2_i == '0 |-> psrc2_o == '0);

  assert_write_seen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && !restore_i |=> map_q[$past(dst_i)*PW +: PW] == $past(wr_tag_i));

endmodule

// File: rtl/rename_unit.sv
module rename_unit #(
  parameter int ARCH_REGS = 32,
  parameter int PHYS_REGS = 64,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int PW = $clog2(PHYS_REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rn_valid,
  input  logic          rn_has_dst,
  input  logic [AW-1:0] rn_dst,
  input  logic [AW-1:0] rn_src1,
  input  logic [AW-1:0] rn_src2,
  input  logic          rn_branch,
  input  logic          mispredict,
  input  logic          cm_free_valid,
  input  logic [PW-1:0] cm_free_tag,
  input  logic          sq_free_valid,
  input  logic [PW-1:0] sq_free_tag,
  output logic          rn_stall,
  output logic [PW-1:0] rn_psrc1,
  output logic [PW-1:0] rn_psrc2,
  output logic [PW-1:0] rn_pdst,
  output logic [PW-1:0] rn_pold
);
  import rename_pkg::*;

  logic          need_dst, fire, alloc, fl_empty;
  logic [PW-1:0] fl_tag, map_pold;

  assign need_dst = needs_dest(rn_has_dst, rn_dst != '0);
  assign rn_stall = rn_valid & (mispredict | (need_dst & fl_empty));
  assign fire     = rn_valid & ~rn_stall;
  assign alloc    = fire & need_dst;

  assign rn_pdst  = alloc ? fl_tag   : '0;
  assign rn_pold  = alloc ? map_pold : '0;

  rename_freelist #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_freelist (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_en_i   (alloc),
    .free_a_v_i   (cm_free_valid),
    .free_a_tag_i (cm_free_tag),
    .free_b_v_i   (sq_free_valid),
    .free_b_tag_i (sq_free_tag),
    .empty_o      (fl_empty),
    .alloc_tag_o  (fl_tag)
  );

  rename_map #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_map (
    .clk       (clk),
    .rst_n     (rst_n),
    .src1_i    (rn_src1),
    .src2_i    (rn_src2),
    .dst_i     (rn_dst),
    .wr_en_i   (alloc),
    .wr_tag_i  (fl_tag),
    .ckpt_en_i (fire & rn_branch),
    .restore_i (mispredict),
    .psrc1_o   (rn_psrc1),
    .psrc2_o   (rn_psrc2),
    .pold_o    (map_pold)
  );

  assert_stall_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rn_valid && rn_stall && !mispredict |-> fl_empty);

  assert_mispredict_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rn_valid && mispredict |-> rn_stall);

  assert_no_dst_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rn_valid && !need_dst |-> !rn_stall || mispredict);

endmodule

// File: tb/rename_unit_tb.sv
module rename_unit_tb;
  localparam int NA = 8;
  localparam int NP = 16;
  localparam int AW = $clog2(NA);
  localparam int PW = $clog2(NP);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rn_valid, rn_has_dst, rn_branch, mispredict;
  logic [AW-1:0] rn_dst, rn_src1, rn_src2;
  logic          cm_free_valid, sq_free_valid;
  logic [PW-1:0] cm_free_tag, sq_free_tag;
  logic          rn_stall;
  logic [PW-1:0] rn_psrc1, rn_psrc2, rn_pdst, rn_pold;

  always #10 clk = ~clk;

  rename_unit #(.ARCH_REGS(NA), .PHYS_REGS(NP)) u_dut (.*);

  int tests = 0;
  int fails = 0;

  // Bench model of the requirements.
  int m_map [NA];
  int m_ckpt[NA];
  bit m_free[NP];
  int pq[64];
  int qh = 0, qt = 0;
  int last_pdst = 0;

  task automatic check(input int act, input int exp, input string req);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lowest_free();
    for (int i = 0; i < NP; i++) if (m_free[i]) return i;
    return -1;
  endfunction

  task automatic step(input bit v, input bit hd, input int d, input int s1, input int s2,
                      input bit br, input bit mp, input bit cv, input int ct,
                      input bit sv, input int st);
    bit need, estall, fire;
    int ep;
    @(negedge clk);
    rn_valid = v; rn_has_dst = hd; rn_dst = AW'(d); rn_src1 = AW'(s1); rn_src2 = AW'(s2);
    rn_branch = br; mispredict = mp;
    cm_free_valid = cv; cm_free_tag = PW'(ct); sq_free_valid = sv; sq_free_tag = PW'(st);
    #2;
    need   = hd && d != 0;
    ep     = lowest_free();
    estall = v && (mp || (need && ep < 0));
    fire   = v && !estall;
    if (v) check(int'(rn_stall), int'(estall), mp ? "R8 stall" : "R6 stall");
    if (fire) begin
      check(int'(rn_psrc1), m_map[s1], s1 == 0 ? "R10 psrc1" : (s1 == d && need) ? "R4 psrc1" : "R2 psrc1");
      check(int'(rn_psrc2), m_map[s2], s2 == 0 ? "R10 psrc2" : "R2 psrc2");
      check(int'(rn_pdst), need ? ep : 0, need ? "R2 pdst" : "R5 pdst");
      check(int'(rn_pold), need ? m_map[d] : 0, need ? "R3 pold" : "R5 pold");
    end
    @(posedge clk);
    if (fire && need) begin
      pq[qt % 64] = m_map[d]; qt++;
      m_map[d] = ep; m_free[ep] = 1'b0; last_pdst = ep;
    end
    if (fire && br) m_ckpt = m_map;
    if (mp) m_map = m_ckpt;
    if (cv) m_free[ct] = 1'b1;
    if (sv) m_free[st] = 1'b1;
    #1;
    rn_valid = 1'b0; rn_branch = 1'b0; mispredict = 1'b0;
    cm_free_valid = 1'b0; sq_free_valid = 1'b0;
  endtask

  task automatic rename(input bit hd, input int d, input int s1, input int s2);
    step(1, hd, d, s1, s2, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int b_tag, b_qt, lf, t1, t2;
    logic [15:0] r;
    rst_n = 1'b0;
    rn_valid = 0; rn_has_dst = 0; rn_dst = '0; rn_src1 = '0; rn_src2 = '0;
    rn_branch = 0; mispredict = 0;
    cm_free_valid = 0; cm_free_tag = '0; sq_free_valid = 0; sq_free_tag = '0;
    for (int i = 0; i < NA; i++) begin m_map[i] = i; m_ckpt[i] = i; end
    for (int i = 0; i < NP; i++) m_free[i] = (i >= NA);
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;

    // R1: identity map after reset, first allocation is p<NA>
    for (int i = 0; i < NA; i++) rename(0, 0, i, NA - 1 - i);

    // R2 R3 R4: drain the free list, source equal to destination
    for (int i = 0; i < NP - NA + 2; i++) rename(1, 1 + (i % (NA - 1)), 1 + (i % (NA - 1)), 3);
    // R6: held instruction left the map alone
    for (int i = 0; i < NA; i++) rename(0, 0, i, i);
    // R5: no destination / r0 destination pass while empty
    rename(0, 4, 4, 5);
    rename(1, 0, 2, 0);

    // R9: commit and squash both return tags in one cycle
    t1 = pq[qh % 64]; qh++;
    t2 = pq[qh % 64]; qh++;
    step(0, 0, 0, 0, 0, 0, 0, 1, t1, 1, t2);
    check(int'(rn_stall), 0, "R9 idle");

    // R7 R8: branch with destination, later renames, mispredict
    step(1, 1, 2, 2, 6, 1, 0, 0, 0, 0, 0);
    b_qt = qt;
    rename(1, 2, 2, 0);
    b_tag = last_pdst;
    rename(1, 5, 2, 5);
    step(1, 1, 3, 2, 2, 0, 1, 0, 0, 0, 0);
    qt = b_qt;
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, b_tag);
    for (int i = 0; i < NA; i++) rename(0, 0, i, 2);

    // Mixed sweep with commits of replaced mappings
    r = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
      lf = (r[12] && (qt > qh)) ? pq[qh % 64] : -1;
      if (lf >= 0) qh++;
      step(1, r[0] | r[1], int'(r[4:2]), int'(r[7:5]), int'(r[10:8]), 0, 0,
           lf >= 0, lf >= 0 ? lf : 0, 0, 0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule